// File: doc/BRIEF.md
# Multi-Channel Pulse-Width Modulator

This block drives several pulse-width-modulated output pins from one shared source clock. Each channel has one 32-bit control word. The word holds a run bit, a force-high bit, an 8-bit high-time field and a 13-bit clock divider. The divider makes a step pulse once every divider+1 source cycles. An 8-bit phase counter moves forward on each step, so one output period always has 256 steps. The pin is high while the phase is below the high-time field.

Software reaches the control words through a plain register port. A write happens when the write strobe is high on a clock edge. A read returns the addressed word combinationally, in the same cycle. Any change to a control word takes effect on the next cycle. This includes clearing the run bit and changing the high time or divider while the channel runs: the block does not wait for the current period to end.

Top module: `pwmx_top`

## Requirements
- R1: After a synchronous reset, every output pin is 0 and every control word reads 0.
- R2: A control word reads back the last value written to its implemented fields. These are bit 31 (run), bit 24 (force high), bits 23:16 (high time) and bits 12:0 (divider), so the read mask is 0x81FF1FFF. All other bits read 0.
- R3: Channel k sits at byte address 16*k. Any address whose low nibble is not zero, or whose channel number is NUM_CH or more, reads 0, and a write to it changes no channel.
- R4: With divider S, the phase steps once every S+1 source cycles, and one output period lasts 256*(S+1) cycles.
- R5: When the force-high bit is 0, the pin is high for the first D*(S+1) cycles of each period and low for the rest, where D is the high-time field. D=0 gives a constant 0.
- R6: When the run bit and the force-high bit are both 1, the pin stays 1 whatever the high-time field holds.
- R7: A write that sets the run bit on a stopped channel restarts the divider and the phase from zero. The pin is high in the first cycle after the write if D>0 or the force-high bit is set.
- R8: A write that clears the run bit drives the pin to 0 in the next cycle, whatever the phase.
- R9: A write to a running channel changes its output in the next cycle, with no wait for the end of the period.
- R10: Each channel runs from its own control word without disturbing the other channels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared source clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Byte address of the control word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pwm_out | output | NUM_CH | One pulse-width-modulated pin per channel, active high |

## Verification
The assertions check four behaviours on every cycle. A write that clears the run bit leaves the pin low. A running write with the force-high bit set drives the pin high. A running write with zero high time drives the pin low. A word written earlier reads back through the mask, and an unmapped address reads 0. Only the bench's scenarios can show the cycle-exact waveform across whole periods: the high/low split for each divider and high-time pair, the restart from phase zero, the effect of a live write in the middle of a period, and channels running side by side.

// File: rtl/pwmx_pkg.sv
package pwmx_pkg;

    localparam int WORD_W    = 32;
    localparam int SCALE_W   = 13;
    localparam int DUTY_W    = 8;
    localparam int SCALE_LSB = 0;
    localparam int DUTY_LSB  = 16;
    localparam int FULL_BIT  = 24;
    localparam int RUN_BIT   = 31;
    localparam int SLOT_SH   = 4;
    localparam logic [WORD_W-1:0] WORD_MASK = 32'h81FF_1FFF;

    typedef struct packed {
        logic               run;
        logic               full;
        logic [DUTY_W-1:0]  duty;
        logic [SCALE_W-1:0] scale;
    } pwmx_cfg_t;

    function automatic pwmx_cfg_t cfg_from_word(input logic [WORD_W-1:0] w);
        pwmx_cfg_t c;
        c.run   = w[RUN_BIT];
        c.full  = w[FULL_BIT];
        c.duty  = w[DUTY_LSB +: DUTY_W];
        c.scale = w[SCALE_LSB +: SCALE_W];
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] word_from_cfg(input pwmx_cfg_t c);
        logic [WORD_W-1:0] w;
        w = '0;
        w[RUN_BIT]                = c.run;
        w[FULL_BIT]               = c.full;
        w[DUTY_LSB +: DUTY_W]     = c.duty;
        w[SCALE_LSB +: SCALE_W]   = c.scale;
        return w;
    endfunction

endpackage

// File: rtl/pwmx_regs.sv
module pwmx_regs
    import pwmx_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [WORD_W-1:0]   bus_wdata,
    output logic [WORD_W-1:0]   bus_rdata,
    output pwmx_cfg_t           cfg_o [NUM_CH]
);

    logic [ADDR_W-1:0] slot;
    logic              hit;

    assign slot = bus_addr >> SLOT_SH;
    assign hit  = (bus_addr[SLOT_SH-1:0] == '0) && (slot < ADDR_W'(NUM_CH));

    for (genvar g = 0; g < NUM_CH; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                cfg_o[g] <= '0;
            else if (bus_we && hit && slot == ADDR_W'(g))
                cfg_o[g] <= cfg_from_word(bus_wdata);
        end
    end

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_CH; i++)
            if (hit && slot == ADDR_W'(i))
                bus_rdata = word_from_cfg(cfg_o[i]);
    end

endmodule

// File: rtl/pwmx_prescale.sv
module pwmx_prescale
    import pwmx_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               run,
    input  logic [SCALE_W-1:0] scale,
    output logic               tick
);

    logic [SCALE_W-1:0] pre_q;

    // greater-or-equal so a smaller divider written mid-count applies at once
    assign tick = run && (pre_q >= scale);

    always_ff @(posedge clk) begin
        if (rst || !run)
            pre_q <= '0;
        else if (tick)
            pre_q <= '0;
        else
            pre_q <= pre_q + 1'b1;
    end

endmodule

// File: rtl/pwmx_chan.sv
module pwmx_chan
    import pwmx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  pwmx_cfg_t cfg_i,
    output logic      pwm_o
);

    logic              tick;
    logic [DUTY_W-1:0] ph_q;

    pwmx_prescale u_pre (
        .clk   (clk),
        .rst   (rst),
        .run   (cfg_i.run),
        .scale (cfg_i.scale),
        .tick  (tick)
    );

    always_ff @(posedge clk) begin
        if (rst || !cfg_i.run)
            ph_q <= '0;
        else if (tick)
            ph_q <= ph_q + 1'b1;
    end

    assign pwm_o = cfg_i.run && (cfg_i.full || (ph_q < cfg_i.duty));

endmodule

// File: rtl/pwmx_top.sv
module pwmx_top
    import pwmx_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [NUM_CH-1:0] pwm_out
);

    pwmx_cfg_t cfg [NUM_CH];

    pwmx_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cfg_o     (cfg)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        pwmx_chan u_ch (
            .clk   (clk),
            .rst   (rst),
            .cfg_i (cfg[g]),
            .pwm_o (pwm_out[g])
        );
    end

endmodule

// File: rtl/pwmx_chk.sv
module pwmx_chk
    import pwmx_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic [NUM_CH-1:0] pwm_out
);

    logic [ADDR_W-1:0] c_slot;
    logic              c_hit;

    assign c_slot = bus_addr >> SLOT_SH;
    assign c_hit  = (bus_addr[SLOT_SH-1:0] == '0) && (c_slot < ADDR_W'(NUM_CH));

    // R2
    rdback_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_we && c_hit) |=> ($stable(bus_addr) -> bus_rdata == ($past(bus_wdata) & WORD_MASK)));

    // R3
    miss_rd_chk: assert property (@(posedge clk) disable iff (rst)
        !c_hit |-> bus_rdata == '0);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_c
        // R8
        stop_low_chk: assert property (@(posedge clk) disable iff (rst)
            (bus_we && c_hit && c_slot == ADDR_W'(g) && !bus_wdata[RUN_BIT]) |=> !pwm_out[g]);
        // R6
        full_high_chk: assert property (@(posedge clk) disable iff (rst)
            (bus_we && c_hit && c_slot == ADDR_W'(g) && bus_wdata[RUN_BIT] && bus_wdata[FULL_BIT])
            |=> pwm_out[g]);
        // R5
        zero_duty_chk: assert property (@(posedge clk) disable iff (rst)
            (bus_we && c_hit && c_slot == ADDR_W'(g) && bus_wdata[RUN_BIT] && !bus_wdata[FULL_BIT]
             && bus_wdata[DUTY_LSB +: DUTY_W] == '0) |=> !pwm_out[g]);
    end

endmodule

bind pwmx_top pwmx_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/pwmx_top_tb.sv
`timescale 1ns/1ps
module pwmx_top_tb;

    localparam int NUM_CH = 4;
    localparam int ADDR_W = 8;

    logic              clk = 1'b0;
    logic              rst;
    logic              bus_we;
    logic [ADDR_W-1:0] bus_addr;
    logic [31:0]       bus_wdata;
    logic [31:0]       bus_rdata;
    logic [NUM_CH-1:0] pwm_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    pwmx_top #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
    );

    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // leaves the bench at the negedge right after the updating edge
    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    function automatic logic [31:0] word(input bit run, input bit full, input int duty, input int scale);
        return {run, 6'b0, full, 8'(duty), 3'b0, 13'(scale)};
    endfunction

    // R4 R5 R6 R7: cycle-exact sweep over two periods starting from a fresh enable
    task automatic sweep(input int ch, input int s, input int d, input bit full);
        int  bad = 0;
        bit  first;
        wr(ADDR_W'(ch * 16), word(1'b1, full, d, s));
        first = pwm_out[ch];
        for (int i = 0; i < 2 * 256 * (s + 1); i++) begin
            bit exp;
            exp = full ? 1'b1 : (((i / (s + 1)) % 256) < d);
            if (pwm_out[ch] !== exp) bad++;
            @(negedge clk);
        end
        check($sformatf("R4/R5 s=%0d d=%0d full=%0d mismatches", s, d, full), bad, 0);
        check($sformatf("R7 first cycle s=%0d d=%0d", s, d), first, (full || d > 0));
        wr(ADDR_W'(ch * 16), 32'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        int c1, c2;
        rst = 1'b1; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 outputs", pwm_out, 0);
        for (int k = 0; k < NUM_CH; k++) begin
            rd(ADDR_W'(k * 16), r);
            check("R1 word", r, 0);
        end

        // R2 readback through the mask, unused bits alone read 0
        wr(8'h30, 32'hFFFF_FFFF);
        rd(8'h30, r); check("R2 all ones", r, 32'h81FF_1FFF);
        wr(8'h20, 32'h7E00_E000);
        rd(8'h20, r); check("R2 unused only", r, 0);
        wr(8'h10, word(1'b0, 1'b0, 8'hA5, 13'h1234));
        rd(8'h10, r); check("R2 pattern", r, 32'h00A5_1234);

        // R3 bad offset and out-of-range slot
        wr(8'h30, 32'h0);
        wr(8'h34, 32'hFFFF_FFFF);
        rd(8'h30, r); check("R3 offset write ignored", r, 0);
        rd(8'h34, r); check("R3 offset read", r, 0);
        wr(8'h40, 32'hFFFF_FFFF);
        rd(8'h40, r); check("R3 range read", r, 0);
        rd(8'h00, r); check("R3 ch0 untouched", r, 0);
        check("R3 outputs idle", pwm_out, 0);
        wr(8'h10, 32'h0);

        // R4 R5 R6 R7 sweep
        for (int s = 0; s < 3; s++) begin
            sweep(0, s, 0, 1'b0);
            sweep(0, s, 1, 1'b0);
            sweep(0, s, 128, 1'b0);
            sweep(0, s, 255, 1'b0);
            sweep(1, s, 37, 1'b0);
            sweep(1, s, 0, 1'b1);
            sweep(2, s, 5, 1'b1);
        end

        // R8 stop mid-period while high
        wr(8'h00, word(1'b1, 1'b0, 200, 1));
        repeat (20) @(negedge clk);
        check("R8 high before stop", pwm_out[0], 1);
        wr(8'h00, word(1'b0, 1'b0, 200, 1));
        check("R8 low after stop", pwm_out[0], 0);

        // R9 live changes take effect at once
        wr(8'h00, word(1'b1, 1'b0, 200, 0));
        repeat (50) @(negedge clk);
        check("R9 high at phase ~51", pwm_out[0], 1);
        wr(8'h00, word(1'b1, 1'b0, 10, 0));
        check("R9 low after duty cut", pwm_out[0], 0);
        wr(8'h00, word(1'b1, 1'b0, 255, 0));
        check("R9 high after duty raise", pwm_out[0], 1);
        wr(8'h00, 32'h0);

        // R10 two channels side by side
        wr(8'h10, word(1'b1, 1'b0, 64, 0));
        wr(8'h20, word(1'b1, 1'b0, 192, 0));
        c1 = 0; c2 = 0;
        for (int i = 0; i < 256; i++) begin
            c1 += int'(pwm_out[1]);
            c2 += int'(pwm_out[2]);
            @(negedge clk);
        end
        check("R10 ch1 high count", c1, 64);
        check("R10 ch2 high count", c2, 192);
        check("R10 idle channels", {pwm_out[3], pwm_out[0]}, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule